// File: doc/BRIEF.md
# Urgency-Counter Weighted Round-Robin Arbiter

This block picks one queue per request from a parameterised set of queues, so that over time each queue receives grants in proportion to its configured weight. Every queue carries an unsigned urgency counter. On a request, the counter of each active queue grows by that queue's weight. The active queue whose grown counter is largest wins. The winner then gives back the total weight of all queues that were active in that selection. Because the amount handed out equals the amount taken back, the spread of grants stays smooth and no queue waits for long.

Weights are loaded through a small write port while the arbiter is held in configuration mode. Leaving that mode starts every counter from the midpoint value. In normal operation the caller presents a per-queue activity mask and a request strobe in the same cycle, and reads the registered grant one cycle later. A flat comparator tree finds the largest counter in a single cycle, so a new grant can be made in every cycle.

Top module: `wrr_urgency_arbiter`

## Requirements
- R1: After reset, grant_valid_o is low, every weight is 1, and every counter sits at the midpoint 2^(QID_BITS+WT_BITS), written as a one in the top bit followed by zeros.
- R2: In a selection, the counter of each queue whose active_i bit is 1 grows by that queue's weight. Counters of inactive queues do not change.
- R3: A selection made at a rising edge with req_i=1, cfg_en_i=0 and at least one active_i bit set drives grant_valid_o=1 on the next cycle. In that cycle grant_id_o holds the binary index of the active queue with the largest counter after the increment.
- R4: After the increment, the winner's counter is reduced by the sum of the weights of all queues active in that selection.
- R5: If two or more active queues have equal largest counters, the lowest queue index wins.
- R6: Counters are QID_BITS+WT_BITS+1 bits wide and never overflow or underflow. The sum of all counters always equals the queue count times the midpoint.
- R7: With a fixed active set and fixed weights, an active queue of weight w is granted within ceil(2*S/w) selections, where S is the sum of the active weights.
- R8: In a cycle with req_i=0 or with all active_i bits at 0, the next cycle has grant_valid_o=0 and no counter changes.
- R9: While cfg_en_i=1, a cfg_we_i pulse stores cfg_wt_i as the weight of queue cfg_qid_i, requests are not served, and all counters are held at the midpoint. A cfg_we_i pulse while cfg_en_i=0 has no effect.
- R10: With a fixed active set, starting from midpoint counters, the first S selections grant each active queue exactly as many times as its weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Configuration mode; holds counters at midpoint |
| cfg_we_i | input | 1 | Weight write strobe |
| cfg_qid_i | input | QID_BITS | Queue index to write |
| cfg_wt_i | input | WT_BITS | Weight value to write |
| req_i | input | 1 | Selection request strobe |
| active_i | input | 2^QID_BITS | Per-queue active mask |
| grant_valid_o | output | 1 | Grant made in the previous cycle |
| grant_id_o | output | QID_BITS | Index of the granted queue |

## Verification
The bench sweeps every non-empty active mask of four queues under several weight sets. For each sweep it restarts from midpoint counters and compares every grant against an arithmetic model. If the tie order were reversed, the first grant after a restart with equal weights would go to a higher index. If the decrement used all weights rather than only the active ones, the grant counts per period would drift away from the weights, and the period-share and waiting-bound checks would catch this. A run with mask and request changing from one step to the next tests that inactive counters hold and that idle cycles change nothing: either error would shift every later grant. Weight writes made outside configuration mode must leave the following grant sequence unchanged.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  localparam int unsigned DEF_QID_BITS = 2;
  localparam int unsigned DEF_WT_BITS  = 3;

  function automatic int unsigned cnt_width(int unsigned qb, int unsigned wb);
    return qb + wb + 1;
  endfunction
endpackage

// File: rtl/wrr_weight_regs.sv
module wrr_weight_regs #(
  parameter int unsigned QB = 2,
  parameter int unsigned WB = 3,
  localparam int unsigned N = 1 << QB
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_en_i,
  input  logic                  cfg_we_i,
  input  logic [QB-1:0]         cfg_qid_i,
  input  logic [WB-1:0]         cfg_wt_i,
  output logic [N-1:0][WB-1:0]  weights_o
);
  logic [N-1:0][WB-1:0] wt_q;

  for (genvar j = 0; j < N; j++) begin : g_wt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        wt_q[j] <= WB'(1);
      else if (cfg_en_i && cfg_we_i && (cfg_qid_i == QB'(j)))
        wt_q[j] <= cfg_wt_i;
    end
  end

  assign weights_o = wt_q;

  AST_WT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(wt_q)); // R9
endmodule

// File: rtl/wrr_max_tree.sv
module wrr_max_tree #(
  parameter int unsigned QB = 2,
  parameter int unsigned VW = 7,
  localparam int unsigned N = 1 << QB,
  localparam int unsigned NODES = 2 * N - 1
) (
  input  logic [N-1:0][VW-1:0] vals_i,
  input  logic [N-1:0]         valid_i,
  output logic                 win_valid_o,
  output logic [QB-1:0]        win_id_o
);
  logic [VW-1:0] nv  [NODES];
  logic [QB-1:0] nid [NODES];
  logic          nvl [NODES];

  for (genvar j = 0; j < N; j++) begin : g_leaf
    assign nv[N-1+j]  = vals_i[j];
    assign nid[N-1+j] = QB'(j);
    assign nvl[N-1+j] = valid_i[j];
  end

  // left child always covers lower indices, so ties resolve to it
  for (genvar i = 0; i < N - 1; i++) begin : g_node
    logic take_r;
    assign take_r = nvl[2*i+2] && (!nvl[2*i+1] || (nv[2*i+2] > nv[2*i+1]));
    assign nv[i]  = take_r ? nv[2*i+2]  : nv[2*i+1];
    assign nid[i] = take_r ? nid[2*i+2] : nid[2*i+1];
    assign nvl[i] = nvl[2*i+1] | nvl[2*i+2];
  end

  assign win_valid_o = nvl[0];
  assign win_id_o    = nid[0];

  always_comb begin
    if (win_valid_o) begin
      AST_WIN_IS_ACTIVE: assert (valid_i[win_id_o]); // R3
    end
  end
endmodule

// File: rtl/wrr_counter_bank.sv
module wrr_counter_bank #(
  parameter int unsigned QB = 2,
  parameter int unsigned WB = 3,
  localparam int unsigned N  = 1 << QB,
  localparam int unsigned CW = QB + WB + 1,
  localparam int unsigned SW = QB + WB,
  localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}}
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 upd_i,
  input  logic [N-1:0]         active_i,
  input  logic [N-1:0][WB-1:0] weights_i,
  input  logic [QB-1:0]        win_id_i,
  output logic [N-1:0][CW:0]   inc_o
);
  logic [N-1:0][CW-1:0] cnt_q;
  logic [N-1:0][CW:0]   nxt_ext;
  logic [SW-1:0]        sum_act;

  always_comb begin
    sum_act = '0;
    for (int j = 0; j < N; j++)
      if (active_i[j]) sum_act = sum_act + SW'(weights_i[j]);
  end

  for (genvar j = 0; j < N; j++) begin : g_cnt
    assign inc_o[j]   = {1'b0, cnt_q[j]} + (active_i[j] ? (CW+1)'(weights_i[j]) : '0);
    assign nxt_ext[j] = inc_o[j] - ((win_id_i == QB'(j)) ? (CW+1)'(sum_act) : '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q[j] <= MID;
      else if (clear_i) cnt_q[j] <= MID;
      else if (upd_i)   cnt_q[j] <= nxt_ext[j][CW-1:0];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_i |-> !nxt_ext[j][CW]); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i && win_id_i == QB'(j)) |-> (inc_o[j] >= (CW+1)'(sum_act))); // R6
    AST_INACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i && !clear_i && !active_i[j] && win_id_i != QB'(j)) |=> $stable(cnt_q[j])); // R2
  end

  logic [CW+QB-1:0] total;
  always_comb begin
    total = '0;
    for (int j = 0; j < N; j++) total = total + (CW+QB)'(cnt_q[j]);
  end

  AST_SUM_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    total == (CW+QB)'(N) * (CW+QB)'(MID)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !clear_i) |=> $stable(cnt_q)); // R8
  AST_CLEAR_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q[0] == MID)); // R9
endmodule

// File: rtl/wrr_urgency_arbiter.sv
module wrr_urgency_arbiter
  import wrr_pkg::*;
#(
  parameter int unsigned QID_BITS = DEF_QID_BITS,
  parameter int unsigned WT_BITS  = DEF_WT_BITS,
  localparam int unsigned N  = 1 << QID_BITS,
  localparam int unsigned CW = cnt_width(QID_BITS, WT_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_en_i,
  input  logic                cfg_we_i,
  input  logic [QID_BITS-1:0] cfg_qid_i,
  input  logic [WT_BITS-1:0]  cfg_wt_i,
  input  logic                req_i,
  input  logic [N-1:0]        active_i,
  output logic                grant_valid_o,
  output logic [QID_BITS-1:0] grant_id_o
);
  logic [N-1:0][WT_BITS-1:0] weights;
  logic [N-1:0][CW:0]        inc;
  logic                      win_valid;
  logic [QID_BITS-1:0]       win_id;
  logic                      upd;

  wrr_weight_regs #(.QB(QID_BITS), .WB(WT_BITS)) u_wts (
    .clk_i, .rst_ni, .cfg_en_i, .cfg_we_i, .cfg_qid_i, .cfg_wt_i,
    .weights_o (weights)
  );

  wrr_counter_bank #(.QB(QID_BITS), .WB(WT_BITS)) u_cnt (
    .clk_i, .rst_ni,
    .clear_i   (cfg_en_i),
    .upd_i     (upd),
    .active_i  (active_i),
    .weights_i (weights),
    .win_id_i  (win_id),
    .inc_o     (inc)
  );

  wrr_max_tree #(.QB(QID_BITS), .VW(CW + 1)) u_tree (
    .vals_i      (inc),
    .valid_i     (active_i),
    .win_valid_o (win_valid),
    .win_id_o    (win_id)
  );

  assign upd = req_i && !cfg_en_i && win_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_id_o    <= '0;
    end else begin
      grant_valid_o <= upd;
      if (upd) grant_id_o <= win_id;
    end
  end

  AST_GRANT_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> ((($past(active_i) >> grant_id_o) & N'(1)) != '0)); // R3
  AST_REQ_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !cfg_en_i && (|active_i)) |=> grant_valid_o); // R3
  AST_IDLE_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || !(|active_i)) |=> !grant_valid_o); // R8
  AST_CFG_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> !grant_valid_o); // R9
endmodule

// File: tb/wrr_urgency_arbiter_tb.sv
module wrr_urgency_arbiter_tb;
  localparam int QB = 2;
  localparam int WB = 3;
  localparam int N = 1 << QB;
  localparam int MID = 1 << (QB + WB);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_en_i = 1'b0, cfg_we_i = 1'b0;
  logic [QB-1:0] cfg_qid_i = '0;
  logic [WB-1:0] cfg_wt_i = '0;
  logic req_i = 1'b0;
  logic [N-1:0] active_i = '0;
  logic grant_valid_o;
  logic [QB-1:0] grant_id_o;

  always #5 clk = ~clk;

  wrr_urgency_arbiter #(.QID_BITS(QB), .WT_BITS(WB)) u_dut (
    .clk_i(clk), .rst_ni, .cfg_en_i, .cfg_we_i, .cfg_qid_i, .cfg_wt_i,
    .req_i, .active_i, .grant_valid_o, .grant_id_o
  );

  int n_cmp = 0, n_bad = 0;
  int cnt [N];
  int wt  [N];
  int last_id;
  int last_vld;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // one selection step: starts and ends at a falling edge
  task automatic step(input logic [N-1:0] mask, input bit rq, input string tag);
    int sum, best;
    active_i = mask; req_i = rq;
    best = -1; sum = 0;
    if (rq && mask != 0) begin
      for (int j = 0; j < N; j++) if (mask[j]) begin
        cnt[j] += wt[j]; sum += wt[j];
      end
      for (int j = 0; j < N; j++)
        if (mask[j] && (best < 0 || cnt[j] > cnt[best])) best = j;
      cnt[best] -= sum;
    end
    @(negedge clk);
    last_vld = grant_valid_o; last_id = grant_id_o;
    if (best < 0) chk(grant_valid_o == 1'b0, {tag, " valid"}, int'(grant_valid_o), 0);
    else begin
      chk(grant_valid_o == 1'b1, {tag, " valid"}, int'(grant_valid_o), 1);
      chk(int'(grant_id_o) == best, {tag, " id"}, int'(grant_id_o), best);
    end
  endtask

  task automatic configure(input int w0, input int w1, input int w2, input int w3);
    int nw [N];
    nw[0] = w0; nw[1] = w1; nw[2] = w2; nw[3] = w3;
    cfg_en_i = 1'b1; req_i = 1'b1; active_i = '1;
    for (int q = 0; q < N; q++) begin
      cfg_we_i = 1'b1; cfg_qid_i = QB'(q); cfg_wt_i = WB'(nw[q]);
      @(negedge clk);
      chk(grant_valid_o == 1'b0, "R9 no grant in cfg", int'(grant_valid_o), 0);
    end
    cfg_we_i = 1'b0; cfg_en_i = 1'b0; req_i = 1'b0;
    for (int q = 0; q < N; q++) begin wt[q] = nw[q]; cnt[q] = MID; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int j = 0; j < N; j++) begin cnt[j] = MID; wt[j] = 1; end
    repeat (3) @(negedge clk);
    chk(grant_valid_o == 1'b0, "R1 reset valid", int'(grant_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(grant_valid_o == 1'b0, "R1 after reset", int'(grant_valid_o), 0);
    // R1: unit weights, midpoint counters -> plain rotation 0,1,2,3
    for (int k = 0; k < 8; k++) begin
      step(4'hF, 1'b1, "R1 rotation");
      chk(last_id == (k % N), "R1 rotation order", last_id, k % N);
    end

    // R5: equal weights, equal counters -> lowest active index first
    configure(5, 5, 5, 5);
    step(4'b1010, 1'b1, "R5 tie");
    chk(last_id == 1, "R5 tie lowest id", last_id, 1);
    configure(3, 3, 3, 3);
    step(4'b1100, 1'b1, "R5 tie");
    chk(last_id == 2, "R5 tie lowest id", last_id, 2);

    // R3 R4 R7 R10: every mask under several weight sets
    for (int s = 0; s < 6; s++) begin
      for (int m = 1; m < 16; m++) begin
        int sw, gap [N], got [N];
        configure(((s*3) % 7) + 1, ((s*3 + 5) % 7) + 1, ((s*3 + 3) % 7) + 1, ((s*5 + 6) % 7) + 1);
        sw = 0;
        for (int j = 0; j < N; j++) begin
          gap[j] = 0; got[j] = 0;
          if (m[j]) sw += wt[j];
        end
        for (int k = 0; k < 2 * sw; k++) begin
          step(m[N-1:0], 1'b1, "R3 R4 sweep");
          for (int j = 0; j < N; j++) if (m[j]) gap[j]++;
          if (last_vld == 1) begin
            if (gap[last_id] > (2*sw + wt[last_id] - 1) / wt[last_id])
              chk(1'b0, "R7 wait bound", gap[last_id], (2*sw + wt[last_id] - 1) / wt[last_id]);
            gap[last_id] = 0;
            if (k < sw) got[last_id]++;
          end
        end
        for (int j = 0; j < N; j++)
          if (m[j]) chk(got[j] == wt[j], "R10 period share", got[j], wt[j]);
        for (int j = 0; j < N; j++)
          if (m[j]) chk(gap[j] <= (2*sw + wt[j] - 1) / wt[j], "R7 final gap", gap[j],
                        (2*sw + wt[j] - 1) / wt[j]);
      end
    end

    // R2 R8: changing masks, idle cycles and empty masks
    configure(7, 2, 4, 1);
    begin
      logic [7:0] lf;
      lf = 8'hA5;
      for (int k = 0; k < 400; k++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        step(lf[3:0], lf[6] | lf[7], "R2 R8 mixed");
      end
    end
    step(4'h0, 1'b1, "R8 empty mask");
    step(4'hF, 1'b0, "R8 no request");

    // R9: write outside configuration must be ignored
    cfg_we_i = 1'b1; cfg_qid_i = 2'd3; cfg_wt_i = 3'd7;
    step(4'hF, 1'b0, "R9 stray write");
    cfg_qid_i = 2'd1;
    step(4'hF, 1'b0, "R9 stray write");
    cfg_we_i = 1'b0;
    for (int k = 0; k < 40; k++) step(4'hF, 1'b1, "R9 weights kept");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule